// File: doc/BRIEF.md
# Flowing-accumulator systolic matrix multiplier

This block multiplies two N×N signed integer matrices on a grid of identical multiply-add tiles. All three data streams are in motion. Elements of the left operand step one tile per clock along one grid axis. Elements of the right operand step along a second axis. The running sums step along the third direction, which points against the other two. Each tile registers what it receives. One clock later it passes both operands on unchanged and passes on the incoming sum plus the product of the two operands.

Each product term is formed at the tile where an operand pair meets the partial sum it belongs to. The elements of one stream sit three slots apart, so a tile never meets two unrelated valid elements in the same cycle. A skewed feeder drives each matrix element into the edge of its row or column on a fixed step of the run. It drives zero on every other step. The sum inputs along the far edges are tied to zero, so every sum starts from zero.

A collector picks each finished sum off the exit edge on the cycle it arrives. The host presents both matrices in parallel and pulses start. It then waits for the single-cycle done pulse and reads the product from the result port.

Top module: `systolic_matmul`

## Requirements
- R1: After reset is asserted, and at once when it is asserted during a run, busy_o and done_o are low and every element of c_mat_o is zero.
- R2: A start_i that is high at a rising edge while the block is idle makes busy_o high from the next cycle. done_o is high for exactly one cycle, starting after the (5N-3)-th rising edge that follows the sampling edge (7 edges for N=2). busy_o is low in that cycle.
- R3: Element r*N+c of c_mat_o (bits (r*N+c)*AW upward) equals the sum over k of A[r][k]*B[k][c]. Operand element (r,c) occupies bits (r*N+c)*DW upward of its port as a DW-bit two's complement value. Results are AW-bit two's complement, sign-extended. Both matrices are captured at the accepted start, and later changes on the matrix ports do not affect the result.
- R4: start_i raised while busy_o is high, including in the last busy cycle, is ignored: the result and the done timing belong to the accepted start.
- R5: While the block is idle, c_mat_o holds the last result regardless of the matrix ports.
- R6: A start presented in the cycle in which done_o is high is accepted. Its result contains nothing left over from the previous run.
- R7: Full-range operands give exact, unsaturated results, for example (-128)(-128)+(-128)(-128) = 32768 and (-128)(127)+(-128)(127) = -32512.
- R8: A tile forwards the incoming partial sum unchanged when either operand is zero. An all-zero A matrix therefore yields an all-zero product even for a nonzero B matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication; sampled only while idle |
| a_mat_i | input | N*N*DW | Left matrix, row-major, signed elements |
| b_mat_i | input | N*N*DW | Right matrix, row-major, signed elements |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle pulse when all results are captured |
| c_mat_o | output | N*N*AW | Product matrix, row-major, signed elements |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a new start request and the end of a run. The bench raises start_i in the last busy cycle, where it must be dropped. The bench also raises start_i in the cycle in which done_o is high, where it must be accepted. Both cases are judged by the done latency and by comparing the product against a reference computed in the bench. The second pair is the final capture and the stream of fresh elements from the next run. Back-to-back runs with random operands show whether any residue reaches the new sums.

// File: rtl/smm_pkg.sv
`timescale 1ns/1ps
package smm_pkg;

  function automatic int min2(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  // Run step on which an operand with outer index o and inner index k enters the grid edge.
  function automatic int feed_slot(input int o, input int k);
    return o + 2 * k;
  endfunction

  // Run step on which the finished sum (i,j) sits in its exit-edge tile register.
  function automatic int cap_slot(input int i, input int j, input int n);
    return i + j + min2(i, j) + 2 * n - 1;
  endfunction

  function automatic int last_slot(input int n);
    return 5 * n - 4;
  endfunction

endpackage

// File: rtl/smm_tile.sv
`timescale 1ns/1ps
module smm_tile #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [AW-1:0] c_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [AW-1:0] c_o
);

  logic signed [2*DW-1:0] prod;
  logic        [AW-1:0]   prod_ext;

  assign prod     = $signed(a_i) * $signed(b_i);
  assign prod_ext = {{(AW-2*DW){prod[2*DW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0;
      b_o <= '0;
      c_o <= '0;
    end else begin
      a_o <= a_i;
      b_o <= b_i;
      c_o <= c_i + prod_ext;
    end
  end

  assert_zero_operand_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |=> c_o == $past(c_i));

endmodule

// File: rtl/smm_feeder.sv
`timescale 1ns/1ps
module smm_feeder #(
  parameter  int N  = 2,
  parameter  int DW = 8,
  parameter  int SW = 4,
  localparam int G  = 2 * N - 1
) (
  input  logic                 busy_i,
  input  logic [SW-1:0]        step_i,
  input  logic [N*N*DW-1:0]    a_i,
  input  logic [N*N*DW-1:0]    b_i,
  output logic [G-1:0][DW-1:0] a_feed_o,
  output logic [G-1:0][DW-1:0] b_feed_o
);

  for (genvar p = 0; p < G; p++) begin : g_lane
    logic [N-1:0][DW-1:0] a_cand, b_cand;
    logic [DW-1:0]        a_or, b_or;

    for (genvar k = 0; k < N; k++) begin : g_k
      localparam int O = k + p - (N - 1);
      if (O >= 0 && O < N) begin : g_live
        localparam int SLOT = smm_pkg::feed_slot(O, k);
        logic hit;
        assign hit       = busy_i && (step_i == SW'(SLOT));
        assign a_cand[k] = hit ? a_i[(O*N+k)*DW +: DW] : '0;  // A[O][k] on row lane p
        assign b_cand[k] = hit ? b_i[(k*N+O)*DW +: DW] : '0;  // B[k][O] on column lane p
      end else begin : g_dead
        assign a_cand[k] = '0;
        assign b_cand[k] = '0;
      end
    end

    // Slots of one lane differ by 3, so at most one candidate is nonzero.
    always_comb begin
      a_or = '0;
      b_or = '0;
      for (int k = 0; k < N; k++) begin
        a_or = a_or | a_cand[k];
        b_or = b_or | b_cand[k];
      end
    end

    assign a_feed_o[p] = a_or;
    assign b_feed_o[p] = b_or;
  end

endmodule

// File: rtl/smm_grid.sv
`timescale 1ns/1ps
module smm_grid #(
  parameter  int N  = 2,
  parameter  int DW = 8,
  parameter  int AW = 20,
  localparam int G  = 2 * N - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [G-1:0][DW-1:0]         a_feed_i,
  input  logic [G-1:0][DW-1:0]         b_feed_i,
  output logic [G-1:0][G-1:0][AW-1:0]  c_grid_o
);

  logic [DW-1:0] a_w [G][G];
  logic [DW-1:0] b_w [G][G];
  logic [AW-1:0] c_w [G][G];

  // A steps +Q, B steps +P, sums step -P-Q.
  for (genvar p = 0; p < G; p++) begin : g_p
    for (genvar q = 0; q < G; q++) begin : g_q
      logic [DW-1:0] a_in, b_in;
      logic [AW-1:0] c_in;

      if (q == 0) begin : g_ae
        assign a_in = a_feed_i[p];
      end else begin : g_an
        assign a_in = a_w[p][q-1];
      end

      if (p == 0) begin : g_be
        assign b_in = b_feed_i[q];
      end else begin : g_bn
        assign b_in = b_w[p-1][q];
      end

      if (p == G - 1 || q == G - 1) begin : g_ce
        assign c_in = '0;
      end else begin : g_cn
        assign c_in = c_w[p+1][q+1];
      end

      smm_tile #(.DW(DW), .AW(AW)) u_tile (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .a_i    (a_in),
        .b_i    (b_in),
        .c_i    (c_in),
        .a_o    (a_w[p][q]),
        .b_o    (b_w[p][q]),
        .c_o    (c_w[p][q])
      );

      assign c_grid_o[p][q] = c_w[p][q];
    end
  end

endmodule

// File: rtl/smm_collector.sv
`timescale 1ns/1ps
module smm_collector #(
  parameter  int N  = 2,
  parameter  int AW = 20,
  parameter  int SW = 4,
  localparam int G  = 2 * N - 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        busy_i,
  input  logic [SW-1:0]               step_i,
  input  logic [G-1:0][G-1:0][AW-1:0] c_grid_i,
  output logic [N*N*AW-1:0]           c_mat_o
);

  logic [N*N*AW-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (busy_i) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (int'(step_i) == smm_pkg::cap_slot(i, j, N))
            res_q[(i*N+j)*AW +: AW] <=
              c_grid_i[i - smm_pkg::min2(i, j)][j - smm_pkg::min2(i, j)];
        end
      end
    end
  end

  assign c_mat_o = res_q;

  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(res_q));

endmodule

// File: rtl/systolic_matmul.sv
`timescale 1ns/1ps
module systolic_matmul #(
  parameter int N  = 2,
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N*N*DW-1:0] a_mat_i,
  input  logic [N*N*DW-1:0] b_mat_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [N*N*AW-1:0] c_mat_o
);

  localparam int G    = 2 * N - 1;
  localparam int LAST = smm_pkg::last_slot(N);
  localparam int SW   = $clog2(LAST + 2);
  localparam logic [SW-1:0] LastStep = SW'(LAST);

  logic              busy_q, done_q;
  logic [SW-1:0]     step_q;
  logic [N*N*DW-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
          a_q    <= a_mat_i;
          b_q    <= b_mat_i;
        end
      end else if (step_q == LastStep) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  logic [G-1:0][DW-1:0]        a_feed, b_feed;
  logic [G-1:0][G-1:0][AW-1:0] c_grid;

  smm_feeder #(.N(N), .DW(DW), .SW(SW)) u_feeder (
    .busy_i   (busy_q),
    .step_i   (step_q),
    .a_i      (a_q),
    .b_i      (b_q),
    .a_feed_o (a_feed),
    .b_feed_o (b_feed)
  );

  smm_grid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_feed_i (a_feed),
    .b_feed_i (b_feed),
    .c_grid_o (c_grid)
  );

  smm_collector #(.N(N), .AW(AW), .SW(SW)) u_collector (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_q),
    .step_i   (step_q),
    .c_grid_i (c_grid),
    .c_mat_o  (c_mat_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

  assert_start_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: tb/sim_systolic_matmul.sv
`timescale 1ns/1ps
module sim_systolic_matmul;
  localparam int N   = 2;
  localparam int DW  = 8;
  localparam int AW  = 20;
  localparam int LAT = 5 * N - 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [N*N*DW-1:0] a_mat_i = '0;
  logic [N*N*DW-1:0] b_mat_i = '0;
  logic              busy_o, done_o;
  logic [N*N*AW-1:0] c_mat_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  systolic_matmul #(.N(N), .DW(DW), .AW(AW)) u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .a_mat_i (a_mat_i),
    .b_mat_i (b_mat_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .c_mat_o (c_mat_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N*N*DW-1:0] pk(input int e0, input int e1, input int e2, input int e3);
    return {DW'(e3), DW'(e2), DW'(e1), DW'(e0)};
  endfunction

  function automatic logic [N*N*AW-1:0] ref_mul(input logic [N*N*DW-1:0] a,
                                                input logic [N*N*DW-1:0] b);
    logic [N*N*AW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        int acc;
        acc = 0;
        for (int k = 0; k < N; k++)
          acc += int'($signed(a[(i*N+k)*DW +: DW])) * int'($signed(b[(k*N+j)*DW +: DW]));
        r[(i*N+j)*AW +: AW] = AW'(acc);
      end
    end
    return r;
  endfunction

  // Starts at a negedge; returns at the negedge on which done_o is high (or on timeout).
  task automatic run(input logic [N*N*DW-1:0] a, input logic [N*N*DW-1:0] b,
                     input int inj, input string req);
    logic [N*N*AW-1:0] exp;
    int n;
    exp = ref_mul(a, b);
    n = 0;
    a_mat_i = a;
    b_mat_i = b;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    a_mat_i = ~a;
    b_mat_i = b ^ 32'h5a5a_a5a5;
    check(busy_o == 1'b1, "R2", "busy after start", longint'(busy_o), 1);
    check(done_o == 1'b0, "R2", "done low after start", longint'(done_o), 0);
    while (!done_o && n < 4 * LAT) begin
      if (n == inj) start_i = 1'b1;
      @(negedge clk_i);
      n++;
      start_i = 1'b0;
    end
    check(n == LAT, "R2", "done latency", n, LAT);
    check(busy_o == 1'b0, "R2", "busy low with done", longint'(busy_o), 0);
    for (int e = 0; e < N * N; e++)
      check(c_mat_o[e*AW +: AW] == exp[e*AW +: AW], req, $sformatf("element %0d", e),
            longint'($signed(c_mat_o[e*AW +: AW])), longint'($signed(exp[e*AW +: AW])));
  endtask

  task automatic idle(input int cyc);
    logic [N*N*AW-1:0] hold;
    hold = c_mat_o;
    for (int t = 0; t < cyc; t++) begin
      a_mat_i = $urandom();
      b_mat_i = $urandom();
      @(negedge clk_i);
      check(c_mat_o == hold, "R5", "result held while idle",
            longint'(c_mat_o[63:0]), longint'(hold[63:0]));
      check(done_o == 1'b0 && busy_o == 1'b0, "R2", "idle flags",
            longint'({busy_o, done_o}), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags in reset", longint'({busy_o, done_o}), 0);
    check(c_mat_o == '0, "R1", "result in reset", longint'(c_mat_o[63:0]), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 fixed vector
    run(pk(1, 2, 3, 4), pk(5, 6, 7, 8), -1, "R3");
    check(c_mat_o == {AW'(50), AW'(43), AW'(22), AW'(19)}, "R3", "fixed product 19 22 43 50",
          longint'(c_mat_o[63:0]), longint'({AW'(50), AW'(43), AW'(22), AW'(19)}));
    idle(4);

    // R7 extremes
    run(pk(-128, -128, -128, -128), pk(-128, -128, -128, -128), -1, "R7");
    check($signed(c_mat_o[0 +: AW]) == 32768, "R7", "min*min sum",
          longint'($signed(c_mat_o[0 +: AW])), 32768);
    idle(2);
    run(pk(-128, -128, 127, -128), pk(127, -128, 127, 127), -1, "R7");
    check($signed(c_mat_o[0 +: AW]) == -32512, "R7", "min*max sum",
          longint'($signed(c_mat_o[0 +: AW])), -32512);
    idle(2);

    // R8 zero operand matrix after a nonzero run
    run(pk(0, 0, 0, 0), pk(9, -7, 100, -128), -1, "R8");
    check(c_mat_o == '0, "R8", "zero A gives zero", longint'(c_mat_o[63:0]), 0);
    idle(2);

    // R4 start while busy: early and in the last busy cycle
    run(pk(2, -3, 4, 5), pk(-6, 7, 8, -9), 2, "R4");
    idle(2);
    run(pk(11, 12, -13, 14), pk(1, 0, 0, 1), LAT - 1, "R4");
    idle(2);

    // R6 back-to-back: start presented in the done cycle
    run(pk(1, 2, 3, 4), pk(5, 6, 7, 8), -1, "R6");
    run(pk(-1, 0, 0, -1), pk(33, -44, 55, 66), -1, "R6");
    for (int r = 0; r < 6; r++) run($urandom(), $urandom(), -1, "R6");
    idle(2);

    // R3 random runs with occasional start noise
    for (int r = 0; r < 20; r++) begin
      run($urandom(), $urandom(), (r % 4 == 0) ? int'($urandom_range(0, LAT - 1)) : -1, "R3");
      if (r % 3 == 0) idle(1);
    end

    // R1 asynchronous reset during a run
    a_mat_i = pk(1, 2, 3, 4);
    b_mat_i = pk(5, 6, 7, 8);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags after mid-run reset",
          longint'({busy_o, done_o}), 0);
    check(c_mat_o == '0, "R1", "result after mid-run reset", longint'(c_mat_o[63:0]), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(pk(7, -8, 9, 10), pk(-1, 2, -3, 4), -1, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule